// File: doc/BRIEF.md
# Error Event Recorder with Interrupt and Reinit Control

This block collects error events for a serial switch port and makes them visible through a byte-wide register interface. Four error categories are tracked: clock, data recovery, threshold and link. Each category has a 16-bit sticky register. A one-cycle pulse on bit n of a category's event input sets bit n of that register. Software reads each register as two bytes. A read of either byte empties the whole register.

A control register chooses, for each category, two separate things. One choice is whether a nonzero register pulls the active-low interrupt line. The other is whether it asks the link logic to restart link initialisation. A status register shows which categories currently hold a nonzero value. A second control register holds a 4-bit cell clock delay and a self-test enable, and drives both out of the block. Reset clears every register.

Top module: `errstat_regs`

## Requirements
- R1: While and after reset, every register is zero. `irq_n` is 1, `reinit_req` is 0, `cell_delay` is 0, `selftest_en` is 0, and every address reads 0.
- R2: The control register is at address 1 and can be read and written. Bits 7..4 are the reinit enables and bits 3..0 are the interrupt enables. Within each group, from high bit to low bit, the categories are clock, data, threshold, link.
- R3: The register at address 2 can be read and written. Bit 7 drives `selftest_en` and bits 3..0 drive `cell_delay`. Bits 6..4 always read 0.
- R4: Each error register is a bit-set accumulator. An event pulse on bit n sets bit n. Address 4+2k reads the low byte of category k and address 5+2k reads the high byte, with k = 0 clock, 1 data, 2 threshold, 3 link. Address bit 5 is ignored when decoding.
- R5: A read strobe at either byte address of a category clears all 16 bits of that register at the clock edge. An event that arrives in the same cycle as the clearing read is kept in the register.
- R6: Writes to address 0 and to addresses 4..11 have no effect on any register.
- R7: Address 0 reads the nonzero flags, one per category: bit 3 clock, bit 2 data, bit 1 threshold, bit 0 link. Bits 7..4 read 0.
- R8: `irq_n` is 0 exactly when some category has a nonzero register and its interrupt enable set.
- R9: `reinit_req` is high for one cycle when a category's condition becomes true. The condition is that the register is nonzero and the category's reinit enable is set. No further pulse follows while that condition stays true.
- R10: Address 3 and addresses 12..31 read 0, with bit 5 ignored.
- R11: `rdata` is combinational from `addr`. It shows the register value before any clear that the same read strobe causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 6 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; triggers clear-on-read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| evt_clk | input | 16 | Clock error event pulses |
| evt_data | input | 16 | Data recovery error event pulses |
| evt_thr | input | 16 | Threshold error event pulses |
| evt_link | input | 16 | Link error event pulses |
| irq_n | output | 1 | Active-low interrupt |
| reinit_req | output | 1 | One-cycle link reinitialisation request |
| cell_delay | output | 4 | Cell clock delay setting |
| selftest_en | output | 1 | Self-test enable |

## Verification
The bench sets every bit of every category and reads the low byte first on some runs and the high byte first on others. A design that clears only the byte it reads would return a stale high byte. A design with a wrong address pairing or a decode that looks at address bit 5 would return data from the wrong place. An event that lands in the same cycle as a clearing read must survive; a design that lets the clear win would lose it. All 16 enable patterns are applied to every category for both the interrupt and the reinit request. The bench confirms that a second event on an already nonzero register gives no second request, which catches a design that pulses on each event instead of on the condition becoming true.

// File: rtl/errstat_regs.sv
module errstat_regs #(
  parameter int ERR_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [ERR_W-1:0] evt_clk,
  input  logic [ERR_W-1:0] evt_data,
  input  logic [ERR_W-1:0] evt_thr,
  input  logic [ERR_W-1:0] evt_link,
  output logic       irq_n,
  output logic       reinit_req,
  output logic [3:0] cell_delay,
  output logic       selftest_en
);
  localparam int NCAT = 4;

  logic [ERR_W-1:0] err [NCAT];
  logic [ERR_W-1:0] evt [NCAT];
  logic [7:0]       ctrl;
  logic [7:0]       cfg;
  logic [NCAT-1:0]  nz;
  logic [NCAT-1:0]  rd_hit;
  logic [NCAT-1:0]  cond, cond_q;

  assign evt[0] = evt_clk;
  assign evt[1] = evt_data;
  assign evt[2] = evt_thr;
  assign evt[3] = evt_link;

  for (genvar k = 0; k < NCAT; k++) begin : g_cat
    assign nz[NCAT-1-k]     = |err[k];
    assign rd_hit[k]        = rd_en && (addr[4:1] == 4'(2 + k));
    assign cond[NCAT-1-k]   = nz[NCAT-1-k] && ctrl[4 + NCAT-1-k];

    always_ff @(posedge clk) begin
      if (!rst_n) err[k] <= '0;
      else        err[k] <= (rd_hit[k] ? '0 : err[k]) | evt[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      cfg    <= '0;
      cond_q <= '0;
    end else begin
      cond_q <= cond;
      if (wr_en && addr[4:0] == 5'd1) ctrl <= wdata;
      if (wr_en && addr[4:0] == 5'd2) cfg  <= {wdata[7], 3'b000, wdata[3:0]};
    end
  end

  always_comb begin
    case (addr[4:0])
      5'd0:    rdata = {4'b0000, nz};
      5'd1:    rdata = ctrl;
      5'd2:    rdata = cfg;
      5'd4:    rdata = err[0][7:0];
      5'd5:    rdata = err[0][15:8];
      5'd6:    rdata = err[1][7:0];
      5'd7:    rdata = err[1][15:8];
      5'd8:    rdata = err[2][7:0];
      5'd9:    rdata = err[2][15:8];
      5'd10:   rdata = err[3][7:0];
      5'd11:   rdata = err[3][15:8];
      default: rdata = 8'h00;
    endcase
  end

  assign irq_n       = ~|(nz & ctrl[3:0]);
  assign reinit_req  = |(cond & ~cond_q);
  assign cell_delay  = cfg[3:0];
  assign selftest_en = cfg[7];
endmodule

// File: rtl/errstat_regs_chk.sv
module errstat_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  wdata,
  input logic [15:0] evt_clk,
  input logic [15:0] evt_data,
  input logic [15:0] evt_thr,
  input logic [15:0] evt_link,
  input logic        irq_n,
  input logic        reinit_req,
  input logic [15:0] err_clk,
  input logic [7:0]  ctrl,
  input logic [3:0]  nz
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq_n && !reinit_req));

  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[4:0] == 5'd1) |=> ctrl == $past(wdata));

  assert_accumulate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clk != 16'h0) |=> ((err_clk & $past(evt_clk)) == $past(evt_clk)));

  assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[4:1] == 4'd2 && evt_clk == 16'h0) |=> err_clk == 16'h0);

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en && evt_clk == 0 && evt_data == 0 && evt_thr == 0 && evt_link == 0)
      |=> $stable(irq_n));

  assert_reinit_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_req |-> |(nz & ctrl[7:4]));
endmodule

bind errstat_regs errstat_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .evt_clk(evt_clk), .evt_data(evt_data), .evt_thr(evt_thr),
  .evt_link(evt_link), .irq_n(irq_n), .reinit_req(reinit_req),
  .err_clk(err[0]), .ctrl(ctrl), .nz(nz)
);

// File: tb/errstat_regs_tb.sv
module errstat_regs_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic [5:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic [15:0] evt_clk = 0, evt_data = 0, evt_thr = 0, evt_link = 0;
  logic irq_n, reinit_req, selftest_en;
  logic [3:0] cell_delay;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  errstat_regs dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .evt_clk(evt_clk), .evt_data(evt_data),
    .evt_thr(evt_thr), .evt_link(evt_link), .irq_n(irq_n),
    .reinit_req(reinit_req), .cell_delay(cell_delay), .selftest_en(selftest_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic set_evt(input int k, input logic [15:0] v);
    case (k)
      0: evt_clk = v;
      1: evt_data = v;
      2: evt_thr = v;
      default: evt_link = v;
    endcase
  endtask

  // pulse one event, return reinit_req in the cycle after and the cycle after that
  task automatic pulse(input int k, input logic [15:0] v, output logic r1, output logic r2);
    @(negedge clk); set_evt(k, v);
    @(negedge clk); set_evt(k, 16'h0); r1 = reinit_req;
    @(negedge clk); r2 = reinit_req;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic r1, r2;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 irq_n", int'(irq_n), 1);
    chk("R1 reinit", int'(reinit_req), 0);
    rst_n = 1;
    for (int a = 0; a < 32; a++) begin
      rd(6'(a), d); chk("R1 read zero", d, 0);
    end
    chk("R1 cell_delay", cell_delay, 0);
    chk("R1 selftest", int'(selftest_en), 0);

    // R10: unmapped addresses, R2/R3 registers
    for (int v = 0; v < 256; v += 37) begin
      wr(6'd1, 8'(v)); rd(6'd1, d); chk("R2 ctrl rw", d, v);
      wr(6'd34, 8'(v)); rd(6'd2, d); chk("R3 cfg rw", d, v & 8'h8F);
      chk("R3 cell_delay", cell_delay, v & 15);
      chk("R3 selftest", int'(selftest_en), (v >> 7) & 1);
      wr(6'd3, 8'(v)); rd(6'd3, d); chk("R10 addr3", d, 0);
      wr(6'd12, 8'(v)); rd(6'd44, d); chk("R10 addr12", d, 0);
    end
    wr(6'd1, 8'h00);

    // R4/R5/R7/R11: every bit of every category, alternating byte order
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < 16; b++) begin
        logic [15:0] v;
        logic [5:0] lo, hi;
        v = 16'(1) << b;
        lo = 6'(4 + 2*k) | ((b & 1) ? 6'd32 : 6'd0);
        hi = lo + 6'd1;
        pulse(k, v, r1, r2);
        rd(6'd0, d); chk("R7 status", d, 1 << (3-k));
        if (b & 2) begin
          rd(hi, d); chk("R4 high byte", d, v[15:8]);
          rd(lo, d); chk("R5 cleared low", d, 0);
        end else begin
          rd(lo, d); chk("R4 low byte", d, v[7:0]);
          rd(hi, d); chk("R5 cleared high", d, 0);
        end
        rd(6'd0, d); chk("R7 status clear", d, 0);
      end
    end

    // R5: event coincident with clearing read is kept
    pulse(0, 16'h0003, r1, r2);
    @(negedge clk); addr = 6'd4; rd_en = 1; evt_clk = 16'h0100; #1 d = rdata;
    chk("R11 read before clear", d, 8'h03);
    @(negedge clk); rd_en = 0; evt_clk = 0;
    rd(6'd5, d); chk("R5 same-cycle event kept", d, 8'h01);
    rd(6'd4, d); chk("R5 cleared after", d, 0);

    // R6: writes to status and error registers ignored
    pulse(2, 16'h0404, r1, r2);
    wr(6'd8, 8'h00); wr(6'd9, 8'hFF); wr(6'd0, 8'hFF);
    rd(6'd0, d); chk("R6 status unchanged", d, 8'h02);
    rd(6'd8, d); chk("R6 low unchanged", d, 8'h04);
    rd(6'd9, d); chk("R6 cleared by read", d, 0);

    // R8: interrupt enables, all patterns
    for (int e = 0; e < 16; e++) begin
      wr(6'd1, 8'(e));
      for (int k = 0; k < 4; k++) begin
        chk("R8 idle high", int'(irq_n), 1);
        pulse(k, 16'h8000, r1, r2);
        chk("R8 irq_n", int'(irq_n), ((e >> (3-k)) & 1) ? 0 : 1);
        chk("R8 no reinit", int'(r1), 0);
        rd(6'(5 + 2*k), d);
        chk("R8 release", int'(irq_n), 1);
      end
    end

    // R9: reinit enables, all patterns
    for (int e = 0; e < 16; e++) begin
      wr(6'd1, 8'(e << 4));
      for (int k = 0; k < 4; k++) begin
        int en;
        en = (e >> (3-k)) & 1;
        pulse(k, 16'h0010, r1, r2);
        chk("R9 pulse", int'(r1), en);
        chk("R9 one cycle", int'(r2), 0);
        chk("R9 irq masked", int'(irq_n), 1);
        pulse(k, 16'h0020, r1, r2);
        chk("R9 no repeat", int'(r1), 0);
        rd(6'(4 + 2*k), d); chk("R9 data", d, 8'h30);
      end
    end
    // R9: enable raised while register already nonzero
    wr(6'd1, 8'h00);
    pulse(3, 16'h0001, r1, r2);
    @(negedge clk); addr = 6'd1; wdata = 8'h10; wr_en = 1;
    @(negedge clk); wr_en = 0; chk("R9 late enable", int'(reinit_req), 1);
    @(negedge clk); chk("R9 late enable one cycle", int'(reinit_req), 0);

    // R1: reset mid-run clears everything
    pulse(1, 16'hFFFF, r1, r2);
    wr(6'd2, 8'h8F);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(6'd0, d); chk("R1 reset status", d, 0);
    rd(6'd1, d); chk("R1 reset ctrl", d, 0);
    rd(6'd7, d); chk("R1 reset err", d, 0);
    chk("R1 reset cfg", cell_delay, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule